// File: doc/BRIEF.md
# Dual-Enable Parallel Memory Bus Decoder

This block sits on the device side of an asynchronous parallel memory port. It reads the two active-low chip enables, the output and write enables and the active-low reset pin, and turns them into one operating mode. The modes are reset, standby, output-disabled, read, write, or an illegal selection. The 16-bit bidirectional data bus is driven only in read mode. In every other mode the block releases it. A small word-addressed register file stands in for the storage array.

The array is split into equal sectors. The two lowest and the two highest sectors are boot sectors, and a write-permit pin guards them. Each write is decided on the first clock of a write access. Exactly one of two status pulses reports the result, and a rejected write leaves the stored word untouched.

Top module: `dual_enable_mem_decoder`

## Requirements
- R1: The device is selected when exactly one of `ce1N`/`ce2N` is low. When selected with `oeN` low and `weN` high, `mode` is 3 (read), `busDrive` is 1 and `dataIo` carries the word stored at `addr`. Either enable alone selects.
- R2: When selected with `oeN` high and `weN` low, `mode` is 4 (write). On the first rising clock edge of that access, the word on `dataIo` is stored at `addr` if the sector is unprotected or `bootWrEn` is 1. `wrDone` is then high for the following clock cycle.
- R3: With both enables high and `resetN` high, `mode` is 1 (standby) and `busDrive` is 0.
- R4: When selected with `oeN` and `weN` both high, or both low, `mode` is 2 (output disabled) and `busDrive` is 0.
- R5: With `resetN` low, `mode` is 0 (reset) whatever the other pins are. `busDrive`, `selErr`, `wrDone` and `wrReject` are 0.
- R6: With both enables low and `resetN` high, `mode` is 5 (illegal), `selErr` is 1 and `busDrive` is 0.
- R7: The sector index is the top `SECT_W` bits of `addr`. Sectors 0, 1, NUM_SECT-2 and NUM_SECT-1 are protected. A write to a protected sector while `bootWrEn` is 0 leaves the stored word unchanged, keeps `wrDone` at 0 and raises `wrReject` for exactly one clock cycle.
- R8: A write to a protected sector while `bootWrEn` is 1 is stored and reported through `wrDone`.
- R9: Holding write mode over several clocks stores only once, using the data at the first edge. Each status pulse lasts one clock cycle, and `wrDone` and `wrReject` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for writes and status |
| resetN | input | 1 | Active-low device reset; also clears status registers |
| ce1N | input | 1 | First active-low chip enable |
| ce2N | input | 1 | Second active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| bootWrEn | input | 1 | High permits writes to boot sectors |
| addr | input | ADDR_W | Word address |
| dataIo | inout | DATA_W | Bidirectional data bus |
| mode | output | 3 | Decoded mode: 0 reset, 1 standby, 2 output disabled, 3 read, 4 write, 5 illegal |
| busDrive | output | 1 | High while the block drives dataIo |
| selErr | output | 1 | High while both enables are low |
| wrDone | output | 1 | One-cycle pulse after an accepted write |
| wrReject | output | 1 | One-cycle pulse after a rejected boot-sector write |

## Verification
The bench uses the defaults: ADDR_W of 6, SECT_W of 3 and DATA_W of 16. That gives eight sectors of eight words, so both protected edges lie within a few addresses. The last word of the highest open sector (0x2F) is close to the first protected word at the top (0x30 to 0x3F). Sector 1 (0x08) and sector 2 (0x10) test the boundary at the low end. With this small array, every write can be read back and compared at the pins.

// File: rtl/mem_decoder_pkg.sv
package mem_decoder_pkg;
  typedef enum logic [2:0] {
    MODE_RESET   = 3'd0,
    MODE_STANDBY = 3'd1,
    MODE_OUTDIS  = 3'd2,
    MODE_READ    = 3'd3,
    MODE_WRITE   = 3'd4,
    MODE_ILLEGAL = 3'd5
  } bus_mode_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } dp_strobe_t;
endpackage

// File: rtl/mem_decoder_ctrl.sv
module mem_decoder_ctrl
  import mem_decoder_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              resetN,
  input  logic              ce1N,
  input  logic              ce2N,
  input  logic              oeN,
  input  logic              weN,
  input  logic              bootWrEn,
  input  logic [ADDR_W-1:0] addr,
  output bus_mode_e         modeNow,
  output logic              selErr,
  output logic              wrDone,
  output logic              wrReject,
  output dp_strobe_t        strb
);
  localparam int NUM_SECT = 1 << SECT_W;

  logic [SECT_W-1:0] sectIdx;
  logic              sectProt;
  logic              inWrite;
  logic              prevWrite;
  logic              writeStart;
  logic              writeOk;

  // pin decode, reset dominant
  always_comb begin
    if (!resetN)                  modeNow = MODE_RESET;
    else if (ce1N && ce2N)        modeNow = MODE_STANDBY;
    else if (!ce1N && !ce2N)      modeNow = MODE_ILLEGAL;
    else if (!oeN && weN)         modeNow = MODE_READ;
    else if (oeN && !weN)         modeNow = MODE_WRITE;
    else                          modeNow = MODE_OUTDIS;
  end

  assign selErr  = (modeNow == MODE_ILLEGAL);
  assign inWrite = (modeNow == MODE_WRITE);

  // boot sectors sit at both ends of the array
  assign sectIdx  = addr[ADDR_W-1 -: SECT_W];
  assign sectProt = (sectIdx < SECT_W'(2)) || (sectIdx >= SECT_W'(NUM_SECT - 2));

  assign writeStart = inWrite && !prevWrite;
  assign writeOk    = !sectProt || bootWrEn;

  assign strb.wrEn = writeStart && writeOk;
  assign strb.rdEn = (modeNow == MODE_READ);

  always_ff @(posedge clk or negedge resetN) begin
    if (!resetN) begin
      prevWrite <= 1'b0;
      wrDone    <= 1'b0;
      wrReject  <= 1'b0;
    end else begin
      prevWrite <= inWrite;
      wrDone    <= writeStart && writeOk;
      wrReject  <= writeStart && !writeOk;
    end
  end

  // R9
  status_excl_chk: assert property (@(posedge clk) disable iff (!resetN)
    $onehot0({wrDone, wrReject}));

  // R7
  reject_pulse_chk: assert property (@(posedge clk) disable iff (!resetN)
    wrReject |=> !wrReject);

  // R7
  reject_cause_chk: assert property (@(posedge clk) disable iff (!resetN)
    wrReject |-> ($past(modeNow) == MODE_WRITE) && !$past(bootWrEn));

  // R2
  done_from_write_chk: assert property (@(posedge clk) disable iff (!resetN)
    wrDone |-> $past(modeNow) == MODE_WRITE);
endmodule

// File: rtl/mem_decoder_dp.sv
module mem_decoder_dp
  import mem_decoder_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              resetN,
  input  dp_strobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dataIo
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [WORDS];
  logic [DATA_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (strb.wrEn) memArr[addr] <= dataIo;
  end

  assign rdWord = memArr[addr];
  assign dataIo = strb.rdEn ? rdWord : {DATA_W{1'bz}};

  // R2
  store_chk: assert property (@(posedge clk) disable iff (!resetN)
    strb.wrEn |=> memArr[$past(addr)] == $past(dataIo));
endmodule

// File: rtl/dual_enable_mem_decoder.sv
module dual_enable_mem_decoder
  import mem_decoder_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              resetN,
  input  logic              ce1N,
  input  logic              ce2N,
  input  logic              oeN,
  input  logic              weN,
  input  logic              bootWrEn,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dataIo,
  output logic [2:0]        mode,
  output logic              busDrive,
  output logic              selErr,
  output logic              wrDone,
  output logic              wrReject
);
  bus_mode_e  modeNow;
  dp_strobe_t strb;

  mem_decoder_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) ctrl_i (
    .clk(clk), .resetN(resetN), .ce1N(ce1N), .ce2N(ce2N), .oeN(oeN),
    .weN(weN), .bootWrEn(bootWrEn), .addr(addr), .modeNow(modeNow),
    .selErr(selErr), .wrDone(wrDone), .wrReject(wrReject), .strb(strb)
  );

  mem_decoder_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .resetN(resetN), .strb(strb), .addr(addr), .dataIo(dataIo)
  );

  assign mode     = modeNow;
  assign busDrive = strb.rdEn;
endmodule

// File: tb/dual_enable_mem_decoder_tb.sv
module dual_enable_mem_decoder_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        resetN, ce1N, ce2N, oeN, weN, bootWrEn;
  logic [5:0]  addr;
  logic [15:0] tbData;
  logic        tbDrv;
  wire  [15:0] dataIo;
  logic [2:0]  mode;
  logic        busDrive, selErr, wrDone, wrReject;
  int nChecks = 0;
  int nFails  = 0;

  assign dataIo = tbDrv ? tbData : 16'hzzzz;

  dual_enable_mem_decoder dut_i (
    .clk(clk), .resetN(resetN), .ce1N(ce1N), .ce2N(ce2N), .oeN(oeN),
    .weN(weN), .bootWrEn(bootWrEn), .addr(addr), .dataIo(dataIo),
    .mode(mode), .busDrive(busDrive), .selErr(selErr), .wrDone(wrDone),
    .wrReject(wrReject)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pins(input logic c1, input logic c2, input logic o, input logic w);
    ce1N = c1; ce2N = c2; oeN = o; weN = w;
  endtask

  task automatic goIdle();
    @(negedge clk);
    pins(1, 1, 1, 1); tbDrv = 1'b0;
  endtask

  // write with status checks; expOk chooses wrDone or wrReject
  task automatic doWrite(input logic [5:0] a, input logic [15:0] d, input logic wp,
                         input logic expOk, input string req);
    @(negedge clk);
    addr = a; tbData = d; tbDrv = 1'b1; bootWrEn = wp; pins(0, 1, 1, 0);
    #1 check({req, " mode write"}, 32'(mode), 32'd4);
    @(posedge clk); #1;
    check({req, " wrDone"}, 32'(wrDone), 32'(expOk));
    check({req, " wrReject"}, 32'(wrReject), 32'(!expOk));
    goIdle();
    @(posedge clk); #1;
    check({req, " pulse ends"}, 32'({wrDone, wrReject}), 32'd0);
  endtask

  task automatic doRead(input logic [5:0] a, input logic useCe2, input logic [15:0] exp,
                        input string req);
    @(negedge clk);
    tbDrv = 1'b0; addr = a;
    if (useCe2) pins(1, 0, 0, 1); else pins(0, 1, 0, 1);
    #1;
    check({req, " mode read"}, 32'(mode), 32'd3);
    check({req, " busDrive"}, 32'(busDrive), 32'd1);
    check({req, " data"}, 32'(dataIo), 32'(exp));
  endtask

  task automatic testReset();
    // R5: reset dominates even with read-like pins
    @(negedge clk);
    resetN = 1'b0; addr = 6'h10; pins(0, 1, 0, 1);
    #1;
    check("R5 mode", 32'(mode), 32'd0);
    check("R5 busDrive", 32'(busDrive), 32'd0);
    check("R5 status", 32'({selErr, wrDone, wrReject}), 32'd0);
    pins(0, 0, 1, 0);
    #1 check("R5 illegal pins masked", 32'({mode, selErr}), 32'd0);
    @(negedge clk); resetN = 1'b1; pins(1, 1, 1, 1);
  endtask

  task automatic testBasicRw();
    doWrite(6'h10, 16'hA5A5, 1'b0, 1'b1, "R2");
    doRead(6'h10, 1'b0, 16'hA5A5, "R1 ce1");
    doRead(6'h10, 1'b1, 16'hA5A5, "R1 ce2");
    doWrite(6'h2F, 16'h0F0F, 1'b0, 1'b1, "R7 open edge");
    doRead(6'h2F, 1'b0, 16'h0F0F, "R7 open edge");
  endtask

  task automatic testProtect();
    doWrite(6'h08, 16'h1111, 1'b1, 1'b1, "R8 low");
    doWrite(6'h08, 16'h2222, 1'b0, 1'b0, "R7 low");
    doRead(6'h08, 1'b0, 16'h1111, "R7 low unchanged");
    doWrite(6'h3F, 16'h3333, 1'b1, 1'b1, "R8 high");
    doWrite(6'h30, 16'h7777, 1'b1, 1'b1, "R8 sect6");
    doWrite(6'h3F, 16'h4444, 1'b0, 1'b0, "R7 high");
    doRead(6'h3F, 1'b1, 16'h3333, "R7 high unchanged");
    doWrite(6'h30, 16'h8888, 1'b0, 1'b0, "R7 sect6");
    doRead(6'h30, 1'b0, 16'h7777, "R7 sect6 unchanged");
  endtask

  task automatic testHold();
    // R9: held write stores once
    @(negedge clk);
    addr = 6'h11; tbData = 16'h5555; tbDrv = 1'b1; bootWrEn = 1'b0; pins(1, 0, 1, 0);
    @(posedge clk); #1 check("R9 first pulse", 32'(wrDone), 32'd1);
    @(negedge clk); tbData = 16'h6666;
    @(posedge clk); #1 check("R9 no second pulse", 32'({wrDone, wrReject}), 32'd0);
    @(posedge clk); #1 check("R9 still quiet", 32'({wrDone, wrReject}), 32'd0);
    goIdle();
    doRead(6'h11, 1'b0, 16'h5555, "R9 first data kept");
  endtask

  task automatic testModes();
    @(negedge clk); tbDrv = 1'b0; pins(1, 1, 0, 1);
    #1 check("R3 standby mode", 32'(mode), 32'd1);
    check("R3 busDrive", 32'(busDrive), 32'd0);
    @(negedge clk); pins(0, 1, 1, 1);
    #1 check("R4 outdis mode", 32'(mode), 32'd2);
    check("R4 busDrive", 32'(busDrive), 32'd0);
    @(negedge clk); pins(1, 0, 0, 0);
    #1 check("R4 both low mode", 32'(mode), 32'd2);
    check("R4 both low busDrive", 32'(busDrive), 32'd0);
    @(negedge clk); pins(0, 0, 0, 1);
    #1 check("R6 mode", 32'(mode), 32'd5);
    check("R6 selErr", 32'(selErr), 32'd1);
    check("R6 busDrive", 32'(busDrive), 32'd0);
    goIdle();
    #1 check("R6 selErr clears", 32'(selErr), 32'd0);
  endtask

  initial begin
    resetN = 1'b0; bootWrEn = 1'b0; addr = '0; tbData = '0; tbDrv = 1'b0;
    pins(1, 1, 1, 1);
    repeat (3) @(posedge clk);
    testReset();
    testBasicRw();
    testProtect();
    testHold();
    testModes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule